// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block turns four power-control bits from the processor status word into a set of graded clock-domain enables. The bits are clock-group select 1, clock-group select 0, oscillator-off and CPU-off. It recognises six operating states: the running state and five sleep levels, each one shutting down more than the one before. For every state it drives one registered enable for each of these: the CPU clock, the system clock, the system-clock frequency-lock loop, the DC generator of the digitally controlled oscillator, and the crystal-derived auxiliary clock.

Software writes the mode bits through a one-cycle write strobe. When the interrupt logic accepts an interrupt, it pulses `irqTake`. The block then saves the current mode bits and clears them, so the chip wakes into the running state. A one-cycle `retiPulse` at the end of the handler puts the saved bits back. The frequency-lock loop can only lock against a running crystal, so its enable is also gated by the `oscReady` handshake from the oscillator model.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: After reset the mode bits are 0000 and the state is running (code 0). The CPU, system-clock, DC-generator and auxiliary-clock enables are 1, and the loop enable is 0.
- R2: Mode bits are packed as bit3 = clock-group select 1, bit2 = clock-group select 0, bit1 = oscillator-off, bit0 = CPU-off. A `srWrite` pulse loads `srBits` at the next rising edge, and `modeBits`, `modeState` and all enables update at that same edge.
- R3: When CPU-off is 0 the state is running (code 0). All enables are 1, except that the loop enable follows `oscReady`.
- R4: With CPU-off = 1, oscillator-off = 0 and selects 00, the state is sleep level 0 (code 1). Only the CPU clock is off. With selects 01 the state is sleep level 1 (code 2), and the loop enable is also 0.
- R5: With CPU-off = 1, oscillator-off = 0 and selects 10, the state is sleep level 2 (code 3). Only the DC-generator and auxiliary-clock enables are 1. With selects 11 the state is sleep level 3 (code 4), and only the auxiliary-clock enable is 1.
- R6: With CPU-off = 1 and oscillator-off = 1, the state is sleep level 4 (code 5) whatever the select bits are. All five enables are 0.
- R7: The loop enable is 1 only if `oscReady` was 1 at the edge that registered it and the decoded state keeps the loop running.
- R8: An `irqTake` pulse stores the current mode bits and clears `modeBits` to 0000 at the next edge, giving the running state.
- R9: A `retiPulse` loads the stored mode bits back into `modeBits` at the next edge.
- R10: `irqTake` takes priority over `retiPulse`, which takes priority over `srWrite`. A lower-priority request in the same cycle has no effect.
- R11: The enables are always graded: the loop enable implies the system-clock enable, and the system-clock enable implies the DC-generator enable. The CPU-clock enable implies the system-clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-up clear |
| srWrite | input | 1 | One-cycle strobe that loads `srBits` |
| srBits | input | 4 | Mode bits to load (packing as in R2) |
| irqTake | input | 1 | Interrupt accepted pulse |
| retiPulse | input | 1 | Return-from-interrupt pulse |
| oscReady | input | 1 | Crystal oscillator is stable |
| modeBits | output | 4 | Mode bits in force |
| modeState | output | 3 | Decoded state code, 0 = running, 1..5 = sleep levels 0..4 |
| cpuClkEn | output | 1 | CPU clock enable |
| mclkEn | output | 1 | System clock enable |
| loopEn | output | 1 | System-clock frequency-lock loop enable |
| dcGenEn | output | 1 | Oscillator DC generator enable |
| aclkEn | output | 1 | Auxiliary crystal clock enable |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. This covers a write, an interrupt entry, a return, and a change on `oscReady` as seen by the loop enable. The bench drives inputs on the falling edge and lets the next rising edge act on them. It then updates its reference model of the mode bits and the stored bits, and compares all outputs one nanosecond after that edge. No result is ever sampled at the edge that produces it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int ModeW  = 4;
  localparam int StateW = 3;
  localparam int EnW    = 5;

  typedef struct packed {
    logic scg1;
    logic scg0;
    logic oscOff;
    logic cpuOff;
  } modeBits_t;

  typedef enum logic [StateW-1:0] {
    ST_RUN  = 3'd0,
    ST_LPM0 = 3'd1,
    ST_LPM1 = 3'd2,
    ST_LPM2 = 3'd3,
    ST_LPM3 = 3'd4,
    ST_LPM4 = 3'd5
  } lpmState_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic loop;
    logic dcGen;
    logic aclk;
  } clkEn_t;

  typedef struct packed {
    logic enterIsr;
    logic takeSaved;
    logic takeWrite;
  } ctrlStrobe_t;

  function automatic lpmState_e decodeState(modeBits_t m);
    lpmState_e s;
    if (!m.cpuOff)     s = ST_RUN;
    else if (m.oscOff) s = ST_LPM4;
    else begin
      case ({m.scg1, m.scg0})
        2'b00:   s = ST_LPM0;
        2'b01:   s = ST_LPM1;
        2'b10:   s = ST_LPM2;
        default: s = ST_LPM3;
      endcase
    end
    return s;
  endfunction

  function automatic clkEn_t enablesFor(lpmState_e s);
    clkEn_t e;
    case (s)
      ST_RUN:  e = '{cpu:1'b1, mclk:1'b1, loop:1'b1, dcGen:1'b1, aclk:1'b1};
      ST_LPM0: e = '{cpu:1'b0, mclk:1'b1, loop:1'b1, dcGen:1'b1, aclk:1'b1};
      ST_LPM1: e = '{cpu:1'b0, mclk:1'b1, loop:1'b0, dcGen:1'b1, aclk:1'b1};
      ST_LPM2: e = '{cpu:1'b0, mclk:1'b0, loop:1'b0, dcGen:1'b1, aclk:1'b1};
      ST_LPM3: e = '{cpu:1'b0, mclk:1'b0, loop:1'b0, dcGen:1'b0, aclk:1'b1};
      default: e = '{cpu:1'b0, mclk:1'b0, loop:1'b0, dcGen:1'b0, aclk:1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srWrite,
  input  logic        irqTake,
  input  logic        retiPulse,
  output ctrlStrobe_t strobe
);

  // Fixed priority: interrupt entry, then return, then software write.
  always_comb begin
    strobe           = '0;
    strobe.enterIsr  = irqTake;
    strobe.takeSaved = retiPulse && !irqTake;
    strobe.takeWrite = srWrite && !irqTake && !retiPulse;
  end

  // R10: at most one source acts on the mode bits in any cycle
  assert_one_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enterIsr, strobe.takeSaved, strobe.takeWrite}));

  // R10: a write that coincides with a higher request must be dropped
  assert_write_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (srWrite && (irqTake || retiPulse)) |-> !strobe.takeWrite);

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  modeBits_t   srBits,
  input  logic        oscReady,
  output modeBits_t   modeQ,
  output lpmState_e   stateQ,
  output clkEn_t      enQ
);

  modeBits_t savedQ;
  modeBits_t modeNext;
  clkEn_t    enNext;
  lpmState_e stateNext;

  always_comb begin
    if (strobe.enterIsr)       modeNext = '0;
    else if (strobe.takeSaved) modeNext = savedQ;
    else if (strobe.takeWrite) modeNext = srBits;
    else                       modeNext = modeQ;
    stateNext  = decodeState(modeNext);
    enNext     = enablesFor(stateNext);
    enNext.loop = enNext.loop & oscReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      savedQ <= '0;
      stateQ <= ST_RUN;
      enQ    <= '{cpu:1'b1, mclk:1'b1, loop:1'b0, dcGen:1'b1, aclk:1'b1};
    end else begin
      modeQ  <= modeNext;
      stateQ <= stateNext;
      enQ    <= enNext;
      if (strobe.enterIsr) savedQ <= modeQ;
    end
  end

  // R8: interrupt entry wakes the CPU and system clock next cycle
  assert_irq_wakes_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterIsr |=> (enQ.cpu && enQ.mclk && stateQ == ST_RUN));

  // R9: return restores the bits that entry stored
  assert_reti_restores_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeSaved |=> (modeQ == $past(savedQ)));

  // R7: loop runs only with a stable crystal at the registering edge
  assert_loop_needs_osc_R7: assert property (@(posedge clk) disable iff (!rstN)
    enQ.loop |-> $past(oscReady));

  // R11: graded enables
  assert_loop_needs_mclk_R11: assert property (@(posedge clk) disable iff (!rstN)
    enQ.loop |-> enQ.mclk);
  assert_mclk_needs_dc_R11: assert property (@(posedge clk) disable iff (!rstN)
    enQ.mclk |-> enQ.dcGen);
  assert_cpu_needs_mclk_R11: assert property (@(posedge clk) disable iff (!rstN)
    enQ.cpu |-> enQ.mclk);

  // R6: auxiliary clock stops only with both CPU-off and oscillator-off set
  assert_aclk_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enQ.aclk |-> (modeQ.cpuOff && modeQ.oscOff));

  // R2: with no strobe the mode bits hold
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(modeQ));

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                srWrite,
  input  logic [ModeW-1:0]    srBits,
  input  logic                irqTake,
  input  logic                retiPulse,
  input  logic                oscReady,
  output logic [ModeW-1:0]    modeBits,
  output logic [StateW-1:0]   modeState,
  output logic                cpuClkEn,
  output logic                mclkEn,
  output logic                loopEn,
  output logic                dcGenEn,
  output logic                aclkEn
);

  ctrlStrobe_t strobe;
  modeBits_t   modeQ;
  lpmState_e   stateQ;
  clkEn_t      enQ;

  lpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srWrite   (srWrite),
    .irqTake   (irqTake),
    .retiPulse (retiPulse),
    .strobe    (strobe)
  );

  lpm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srBits   (modeBits_t'(srBits)),
    .oscReady (oscReady),
    .modeQ    (modeQ),
    .stateQ   (stateQ),
    .enQ      (enQ)
  );

  assign modeBits  = modeQ;
  assign modeState = stateQ;
  assign cpuClkEn  = enQ.cpu;
  assign mclkEn    = enQ.mclk;
  assign loopEn    = enQ.loop;
  assign dcGenEn   = enQ.dcGen;
  assign aclkEn    = enQ.aclk;

endmodule

// File: tb/sim_lpm_mode_ctrl.sv
module sim_lpm_mode_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srWrite = 1'b0;
  logic [3:0] srBits = 4'd0;
  logic       irqTake = 1'b0;
  logic       retiPulse = 1'b0;
  logic       oscReady = 1'b0;
  logic [3:0] modeBits;
  logic [2:0] modeState;
  logic       cpuClkEn, mclkEn, loopEn, dcGenEn, aclkEn;

  int checks = 0;
  int errors = 0;
  logic [3:0] expMode = 4'd0;
  logic [3:0] expSaved = 4'd0;
  logic       expOscAtEdge = 1'b0;

  always #10 clk = ~clk;

  lpm_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .srWrite(srWrite), .srBits(srBits),
    .irqTake(irqTake), .retiPulse(retiPulse), .oscReady(oscReady),
    .modeBits(modeBits), .modeState(modeState), .cpuClkEn(cpuClkEn),
    .mclkEn(mclkEn), .loopEn(loopEn), .dcGenEn(dcGenEn), .aclkEn(aclkEn)
  );

  // State code from the requirement tables (R3..R6)
  function automatic logic [2:0] refState(logic [3:0] m);
    if (!m[0]) return 3'd0;
    if (m[1])  return 3'd5;
    return 3'd1 + {1'b0, m[3:2]};
  endfunction

  // Enables {cpu,mclk,loop,dcGen,aclk} before oscillator gating
  function automatic logic [4:0] refEn(logic [2:0] s);
    case (s)
      3'd0: return 5'b11111;
      3'd1: return 5'b01111;
      3'd2: return 5'b01011;
      3'd3: return 5'b00011;
      3'd4: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    logic [2:0] s;
    logic [4:0] e;
    s = refState(expMode);
    e = refEn(s);
    e[2] = e[2] & expOscAtEdge;
    check(req, 32'(modeBits), 32'(expMode), "modeBits");
    check(req, 32'(modeState), 32'(s), "modeState");
    check(req, 32'({cpuClkEn, mclkEn, loopEn, dcGenEn, aclkEn}), 32'(e), "enables");
  endtask

  // Drive on falling edge, let the rising edge act, compare 1 ns later.
  task automatic step(logic w, logic [3:0] b, logic irq, logic ret, logic osc, string req);
    @(negedge clk);
    srWrite = w; srBits = b; irqTake = irq; retiPulse = ret; oscReady = osc;
    @(posedge clk);
    if (irq) begin
      expSaved = expMode;
      expMode  = 4'd0;
    end else if (ret) expMode = expSaved;
    else if (w) expMode = b;
    expOscAtEdge = osc;
    #1;
    checkAll(req);
    @(negedge clk);
    srWrite = 1'b0; irqTake = 1'b0; retiPulse = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1");
    @(negedge clk);
    rstN = 1'b1;

    // R2..R6: every code, with crystal stable
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 4'(c), 1'b0, 1'b0, 1'b1, (c[0] == 1'b0) ? "R3" :
           (c[1] ? "R6" : (c[3] ? "R5" : "R4")));
    end
    // R7: sleep level 0 without crystal, then with
    step(1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, "R7");
    // R8/R9: sleep level 3, interrupt, return
    step(1'b1, 4'b1101, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, "R8");
    step(1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, "R9");
    // R10: collisions
    step(1'b1, 4'b0011, 1'b1, 1'b1, 1'b1, "R10");
    step(1'b1, 4'b0111, 1'b0, 1'b1, 1'b1, "R10");
    // R6: deepest sleep, selects ignored
    step(1'b1, 4'b0011, 1'b0, 1'b0, 1'b1, "R6");

    // Constrained random mix (R2, R8, R9, R10, R11 via model)
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(($urandom % 3) == 0, r, ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 4) != 0, "R10");
      check("R11", 32'((loopEn & !mclkEn) | (mclkEn & !dcGenEn) | (cpuClkEn & !mclkEn)),
            32'd0, "grading");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule